// File: doc/BRIEF.md
# Byte-Enable Bus Width Converter

This block connects a 32-bit processor port to a 16-bit expansion bus. The processor asks for an access by pulsing a request together with four active-low byte enables, a read/write flag and a memory/I-O select. The block breaks that access into one or more narrower bus cycles. Each cycle is either a single byte or an aligned 16-bit word. For each cycle the block drives the two low address bits and an active-low high-byte enable, and places each write byte on the bus lane that matches its address.

The choice between byte and word cycles follows the slave's 16-bit-capable indication. There are two such inputs, one for memory and one for I/O, and both are active low. On reads, each returned byte is stored in a 32-bit holding register. The assembled word is handed to the processor in a single step when the last cycle completes. While the sequence runs, the processor is held off by a not-ready output. A one-clock done pulse marks the end of the access.

Top module: `bus_width_conv`

## Requirements
- R1: After `req_valid` is accepted in the idle state, `cpu_not_ready` is high from the next clock until the clock on which the final sub-cycle completes. It is high for exactly as many cycles as the bus cycles plus their wait cycles. `cpu_done` is high for exactly one clock, in the first cycle in which `cpu_not_ready` is low again.
- R2: Enable `req_be_n[i]` low selects byte i, which is bits 8i+7:8i of the processor word. A byte cycle at an even byte address k drives `bus_addr_lo` = k (bit 0 is A0, bit 1 is A1) and `bus_hbe_n` high, and it moves the byte on bus lane 7:0.
- R3: A byte cycle at an odd byte address k drives `bus_addr_lo` = k and `bus_hbe_n` low, and it takes read data from bus lane 15:8.
- R4: If the selected width input is low and bytes k and k+1 (k even) are both enabled, one word cycle is run. It drives `bus_addr_lo` = k and `bus_hbe_n` low, and it moves byte k on lane 7:0 and byte k+1 on lane 15:8.
- R5: A four-byte access to an 8-bit slave runs four byte cycles, with `bus_addr_lo` going 0, 1, 2, 3 in that order.
- R6: A four-byte access to a 16-bit slave runs two word cycles, with `bus_addr_lo` going 0 and then 2.
- R7: The slave width comes from `mem_w16_n` when `req_mem` is 1 and from `io_w16_n` when `req_mem` is 0. It is sampled when the request is accepted.
- R8: On a read, `cpu_rdata` changes only in the cycle in which `cpu_done` is high. It then shows the enabled bytes as read, and each byte that was not enabled keeps its value from the previous read.
- R9: Byte enables that are not contiguous are handled by skipping the disabled bytes. Cycles run in ascending address order, and a word cycle is used only for an even-aligned pair in which both bytes are enabled.
- R10: On a write, `bus_wr` is high, and lane 7:0 carries the byte at `bus_addr_lo`. In an odd byte cycle, that byte is on lane 15:8 and is also copied to lane 7:0.
- R11: A sub-cycle completes only on a clock where `bus_ready` is high. Until then, `bus_cyc`, `bus_addr_lo`, `bus_hbe_n` and `bus_wdata` hold their values.
- R12: A request with all four enables high runs no bus cycle. It gives a `cpu_done` pulse on the next clock, and `cpu_not_ready` stays low.
- R13: A `req_valid` pulse while `cpu_not_ready` is high is ignored. It adds no bus cycle, either during the current access or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-clock request strobe from the processor |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_be_n | input | 4 | Active-low byte enables, bit i for byte i |
| req_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Assembled read word |
| cpu_not_ready | output | 1 | High while an access is in progress |
| cpu_done | output | 1 | One-clock end-of-access pulse |
| bus_cyc | output | 1 | A bus sub-cycle is active |
| bus_wr | output | 1 | Active sub-cycle is a write |
| bus_addr_lo | output | 2 | Low byte address of the sub-cycle (bit 0 = A0) |
| bus_hbe_n | output | 1 | Active-low high-byte enable |
| bus_wdata | output | 16 | Bus write lanes |
| bus_rdata | input | 16 | Bus read lanes |
| bus_ready | input | 1 | Slave completes the sub-cycle on this clock |
| mem_w16_n | input | 1 | Memory slave accepts 16-bit cycles (active low) |
| io_w16_n | input | 1 | I/O slave accepts 16-bit cycles (active low) |

## Verification
A corrupted pending-byte mask shows on the bus at once. On the first sub-cycle after the fault, a byte cycle appears where a word cycle was due, or the address is skipped or repeated. The access then ends with the wrong number of not-ready cycles. A wrong latched width bit changes the cycle count and the high-byte enable of the very first cycle. A holding register that loads the wrong lane is only visible when `cpu_done` pulses, as a wrong byte in `cpu_rdata`, or as a stale byte in a later partial read.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bwc_state_e;
endpackage

// File: rtl/bwc_planner.sv
// Picks the next sub-cycle from the mask of bytes still to move.
module bwc_planner #(
  parameter int NUM_BYTES = 4,
  localparam int IDX_W = $clog2(NUM_BYTES)
) (
  input  logic [NUM_BYTES-1:0] pend,
  input  logic                 is_w16,
  output logic [IDX_W-1:0]     idx,
  output logic                 word,
  output logic [NUM_BYTES-1:0] clr_mask,
  output logic                 hbe_n
);
  logic             found;
  logic [IDX_W-1:0] pair_idx;

  // lowest pending byte first
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (!found && pend[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign pair_idx = idx | IDX_W'(1);
  assign word     = is_w16 && !idx[0] && pend[pair_idx];
  assign hbe_n    = !(word || idx[0]);

  always_comb begin
    for (int i = 0; i < NUM_BYTES; i++) begin
      clr_mask[i] = (IDX_W'(i) == idx) || (word && (IDX_W'(i) == pair_idx));
    end
  end
endmodule

// File: rtl/bwc_lanes.sv
// Write lane steering and read gathering into the holding word.
module bwc_lanes #(
  parameter int NUM_BYTES = 4,
  parameter int LANE_W    = 8,
  localparam int DW    = NUM_BYTES * LANE_W,
  localparam int BW    = 2 * LANE_W,
  localparam int IDX_W = $clog2(NUM_BYTES)
) (
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] idx,
  input  logic             word,
  input  logic [BW-1:0]    rdata_bus,
  input  logic [DW-1:0]    hold_q,
  output logic [BW-1:0]    wdata_bus,
  output logic [DW-1:0]    hold_d
);
  logic [IDX_W-1:0]  idx_hi;
  logic [LANE_W-1:0] byte_lo;
  logic [LANE_W-1:0] byte_hi;
  logic [LANE_W-1:0] rd_lo;
  logic [LANE_W-1:0] rd_hi;

  assign idx_hi    = word ? (idx | IDX_W'(1)) : idx;
  assign byte_lo   = wdata[int'(idx) * LANE_W +: LANE_W];
  assign byte_hi   = wdata[int'(idx_hi) * LANE_W +: LANE_W];
  assign wdata_bus = {byte_hi, byte_lo};

  assign rd_lo = rdata_bus[LANE_W-1:0];
  assign rd_hi = rdata_bus[BW-1:LANE_W];

  always_comb begin
    hold_d = hold_q;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (IDX_W'(i) == idx) begin
        hold_d[i*LANE_W +: LANE_W] = idx[0] ? rd_hi : rd_lo;
      end else if (word && (IDX_W'(i) == (idx | IDX_W'(1)))) begin
        hold_d[i*LANE_W +: LANE_W] = rd_hi;
      end
    end
  end
endmodule

// File: rtl/bus_width_conv.sv
module bus_width_conv #(
  parameter int NUM_BYTES = 4,
  parameter int LANE_W    = 8,
  localparam int DW    = NUM_BYTES * LANE_W,
  localparam int BW    = 2 * LANE_W,
  localparam int IDX_W = $clog2(NUM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_mem,
  input  logic [NUM_BYTES-1:0] req_be_n,
  input  logic [DW-1:0]        req_wdata,
  output logic [DW-1:0]        cpu_rdata,
  output logic                 cpu_not_ready,
  output logic                 cpu_done,
  output logic                 bus_cyc,
  output logic                 bus_wr,
  output logic [IDX_W-1:0]     bus_addr_lo,
  output logic                 bus_hbe_n,
  output logic [BW-1:0]        bus_wdata,
  input  logic [BW-1:0]        bus_rdata,
  input  logic                 bus_ready,
  input  logic                 mem_w16_n,
  input  logic                 io_w16_n
);
  import bwc_pkg::*;

  // reset: asserted at once, removed on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bwc_state_e           state_q, state_d;
  logic [NUM_BYTES-1:0] pend_q, pend_d;
  logic                 done_q, done_d;
  logic                 wr_q, w16_q;
  logic [DW-1:0]        wdata_q, hold_q, hold_d, rdata_q;

  logic                 accept, step, last, none_en, w16_sel;
  logic                 hold_en, rdata_en;
  logic [IDX_W-1:0]     cur_idx;
  logic                 cur_word, cur_hbe_n;
  logic [NUM_BYTES-1:0] cur_clr, pend_after;

  bwc_planner #(.NUM_BYTES(NUM_BYTES)) u_planner (
    .pend     (pend_q),
    .is_w16   (w16_q),
    .idx      (cur_idx),
    .word     (cur_word),
    .clr_mask (cur_clr),
    .hbe_n    (cur_hbe_n)
  );

  bwc_lanes #(.NUM_BYTES(NUM_BYTES), .LANE_W(LANE_W)) u_lanes (
    .wdata     (wdata_q),
    .idx       (cur_idx),
    .word      (cur_word),
    .rdata_bus (bus_rdata),
    .hold_q    (hold_q),
    .wdata_bus (bus_wdata),
    .hold_d    (hold_d)
  );

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign step       = (state_q == ST_RUN) && bus_ready;
  assign pend_after = pend_q & ~cur_clr;
  assign last       = step && (pend_after == '0);
  assign none_en    = &req_be_n;
  assign w16_sel    = req_mem ? !mem_w16_n : !io_w16_n;
  assign hold_en    = step && !wr_q;
  assign rdata_en   = last && !wr_q;

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    done_d  = 1'b0;
    if (accept) begin
      pend_d  = ~req_be_n;
      state_d = none_en ? ST_IDLE : ST_RUN;
      done_d  = none_en;
    end else if (step) begin
      pend_d = pend_after;
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_q    <= 1'b0;
      w16_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      w16_q   <= w16_sel;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    rdata_q <= '0;
    else if (rdata_en) rdata_q <= hold_d;
  end

  assign cpu_rdata     = rdata_q;
  assign cpu_done      = done_q;
  assign cpu_not_ready = (state_q == ST_RUN);
  assign bus_cyc       = (state_q == ST_RUN);
  assign bus_wr        = (state_q == ST_RUN) && wr_q;
  assign bus_addr_lo   = cur_idx;
  assign bus_hbe_n     = cur_hbe_n;

  // checks
  p_done_one_clock_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_done |=> !cpu_done);
  p_release_with_done_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(cpu_not_ready) |-> cpu_done);
  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_done |-> !cpu_not_ready);
  p_odd_uses_high_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_cyc && bus_addr_lo[0]) |-> !bus_hbe_n);
  p_rdata_only_at_done_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cpu_done |-> $stable(cpu_rdata));
  p_mask_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_cyc && bus_ready) |=> ($countones(pend_q) < $countones($past(pend_q))));
  p_hold_in_wait_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr_lo)
      && $stable(bus_hbe_n) && $stable(bus_wdata)));
  p_idle_no_cycle_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cpu_not_ready |-> !bus_cyc);
endmodule

// File: tb/test_bus_width_conv.sv
module test_bus_width_conv;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_mem;
  logic [3:0]  req_be_n;
  logic [31:0] req_wdata;
  logic [31:0] cpu_rdata;
  logic        cpu_not_ready, cpu_done;
  logic        bus_cyc, bus_wr, bus_hbe_n, bus_ready;
  logic [1:0]  bus_addr_lo;
  logic [15:0] bus_wdata, bus_rdata;
  logic        mem_w16_n, io_w16_n;

  int n_chk;
  int n_err;

  logic [7:0]  smem [4];
  int          slave_waits;
  int          wait_cnt;
  int          stab_err;
  int          log_cnt;
  logic        waiting;
  logic [1:0]  w_a;
  logic        w_h;
  logic [15:0] w_d;
  logic [1:0]  log_a [8];
  logic        log_h [8];
  logic        log_w [8];
  logic [15:0] log_d [8];

  bus_width_conv i_bus_width_conv (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_mem       (req_mem),
    .req_be_n      (req_be_n),
    .req_wdata     (req_wdata),
    .cpu_rdata     (cpu_rdata),
    .cpu_not_ready (cpu_not_ready),
    .cpu_done      (cpu_done),
    .bus_cyc       (bus_cyc),
    .bus_wr        (bus_wr),
    .bus_addr_lo   (bus_addr_lo),
    .bus_hbe_n     (bus_hbe_n),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_ready     (bus_ready),
    .mem_w16_n     (mem_w16_n),
    .io_w16_n      (io_w16_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // read lanes a requirement-following slave would return
  function automatic logic [15:0] lanes_for(input logic [1:0] a, input logic h);
    if (!h && !a[0]) return {smem[a | 2'd1], smem[a]};
    else if (a[0])   return {smem[a], 8'hDD};
    else             return {8'hEE, smem[a]};
  endfunction

  // slave model, acts away from the active edge
  always @(negedge clk) begin
    if (rst_n && bus_cyc) begin
      if (waiting && (bus_addr_lo != w_a || bus_hbe_n != w_h || bus_wdata != w_d))
        stab_err++;
      if (wait_cnt < slave_waits) begin
        bus_ready = 1'b0;
        wait_cnt++;
        waiting = 1'b1;
        w_a = bus_addr_lo;
        w_h = bus_hbe_n;
        w_d = bus_wdata;
      end else begin
        bus_ready = 1'b1;
        bus_rdata = lanes_for(bus_addr_lo, bus_hbe_n);
        if (log_cnt < 8) begin
          log_a[log_cnt] = bus_addr_lo;
          log_h[log_cnt] = bus_hbe_n;
          log_w[log_cnt] = bus_wr;
          log_d[log_cnt] = bus_wdata;
        end
        log_cnt++;
        wait_cnt = 0;
        waiting  = 1'b0;
      end
    end else begin
      bus_ready = 1'b0;
      wait_cnt  = 0;
      waiting   = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_cyc(input string tag, input int n, input logic [1:0] a, input logic h);
    chk(tag, {29'd0, log_a[n], log_h[n]}, {29'd0, a, h});
  endtask

  task automatic set_mem(input logic [31:0] v);
    for (int i = 0; i < 4; i++) smem[i] = v[i*8 +: 8];
  endtask

  // issue one access and wait for its end; checks R1 timing on the way
  task automatic run_req(input logic wr, input logic mem, input logic [3:0] be_n,
                         input logic [31:0] wd, input logic inject, output int busy,
                         output logic rd_moved);
    logic [31:0] rd0;
    int to;
    @(negedge clk);
    log_cnt   = 0;
    req_write = wr;
    req_mem   = mem;
    req_be_n  = be_n;
    req_wdata = wd;
    req_valid = 1'b1;
    rd0       = cpu_rdata;
    @(negedge clk);
    req_valid = 1'b0;
    busy      = 0;
    rd_moved  = 1'b0;
    to        = 0;
    while (!cpu_done && to < 300) begin
      if (cpu_not_ready) busy++;
      if (cpu_rdata !== rd0) rd_moved = 1'b1;
      if (inject && to == 0) begin
        req_valid = 1'b1;
        req_be_n  = 4'b0000;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      to++;
    end
    req_valid = 1'b0;
    chk("R1 access finished", {31'd0, cpu_done}, 32'd1);
    chk("R1 not-ready low at done", {31'd0, cpu_not_ready}, 32'd0);
    @(negedge clk);
    chk("R1 done lasts one clock", {31'd0, cpu_done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset not_ready", {31'd0, cpu_not_ready}, 32'd0);
    chk("R1 reset done", {31'd0, cpu_done}, 32'd0);
    chk("R12 reset bus_cyc", {31'd0, bus_cyc}, 32'd0);
    chk("R8 reset rdata", cpu_rdata, 32'd0);
  endtask

  task automatic t_even_byte;
    int b; logic m;
    set_mem(32'h44332211);
    mem_w16_n = 1'b1; io_w16_n = 1'b1; slave_waits = 0;
    run_req(1'b0, 1'b1, 4'b1110, 32'd0, 1'b0, b, m);
    chk("R2 even byte cycles", log_cnt, 1);
    chk_cyc("R2 even byte addr/hbe", 0, 2'd0, 1'b1);
    chk("R2 even byte read lane", cpu_rdata, 32'h00000011);
    chk("R1 busy cycles", b, 1);
    chk("R8 rdata held mid-run", {31'd0, m}, 32'd0);
  endtask

  task automatic t_odd_byte;
    int b; logic m;
    run_req(1'b0, 1'b1, 4'b1101, 32'd0, 1'b0, b, m);
    chk("R3 odd byte cycles", log_cnt, 1);
    chk_cyc("R3 odd byte addr/hbe", 0, 2'd1, 1'b0);
    chk("R3 odd byte read lane", cpu_rdata, 32'h00002211);
  endtask

  task automatic t_word;
    int b; logic m;
    set_mem(32'hA3A2A1A0);
    mem_w16_n = 1'b0;
    run_req(1'b0, 1'b1, 4'b1100, 32'd0, 1'b0, b, m);
    chk("R4 word cycles", log_cnt, 1);
    chk_cyc("R4 word addr/hbe", 0, 2'd0, 1'b0);
    chk("R4 word read lanes", cpu_rdata, 32'h0000A1A0);
  endtask

  task automatic t_dword8;
    int b; logic m;
    mem_w16_n = 1'b1;
    run_req(1'b0, 1'b1, 4'b0000, 32'd0, 1'b0, b, m);
    chk("R5 dword to 8-bit cycles", log_cnt, 4);
    chk_cyc("R5 step 0", 0, 2'd0, 1'b1);
    chk_cyc("R5 step 1", 1, 2'd1, 1'b0);
    chk_cyc("R5 step 2", 2, 2'd2, 1'b1);
    chk_cyc("R5 step 3", 3, 2'd3, 1'b0);
    chk("R5 gathered word", cpu_rdata, 32'hA3A2A1A0);
    chk("R8 rdata held during sequence", {31'd0, m}, 32'd0);
    chk("R1 busy cycles for four", b, 4);
  endtask

  task automatic t_dword16;
    int b; logic m;
    set_mem(32'h44332211);
    mem_w16_n = 1'b0;
    run_req(1'b0, 1'b1, 4'b0000, 32'd0, 1'b0, b, m);
    chk("R6 dword to 16-bit cycles", log_cnt, 2);
    chk_cyc("R6 low word", 0, 2'd0, 1'b0);
    chk_cyc("R6 high word", 1, 2'd2, 1'b0);
    chk("R6 gathered word", cpu_rdata, 32'h44332211);
  endtask

  task automatic t_keep_bytes;
    int b; logic m;
    set_mem(32'hB3B2B1B0);
    mem_w16_n = 1'b1;
    run_req(1'b0, 1'b1, 4'b1011, 32'd0, 1'b0, b, m);
    chk("R8 partial read cycles", log_cnt, 1);
    chk_cyc("R8 partial addr/hbe", 0, 2'd2, 1'b1);
    chk("R8 untouched bytes kept", cpu_rdata, 32'h44B22211);
  endtask

  task automatic t_width_select;
    int b; logic m;
    mem_w16_n = 1'b0; io_w16_n = 1'b1;
    run_req(1'b0, 1'b0, 4'b0000, 32'd0, 1'b0, b, m);
    chk("R7 io uses io width (8-bit)", log_cnt, 4);
    mem_w16_n = 1'b1; io_w16_n = 1'b0;
    run_req(1'b0, 1'b0, 4'b1100, 32'd0, 1'b0, b, m);
    chk("R7 io uses io width (16-bit)", log_cnt, 1);
    chk_cyc("R7 io word addr/hbe", 0, 2'd0, 1'b0);
    run_req(1'b0, 1'b1, 4'b1100, 32'd0, 1'b0, b, m);
    chk("R7 mem uses mem width (8-bit)", log_cnt, 2);
    io_w16_n = 1'b1;
  endtask

  task automatic t_sparse;
    int b; logic m;
    mem_w16_n = 1'b0;
    run_req(1'b0, 1'b1, 4'b0101, 32'd0, 1'b0, b, m);
    chk("R9 odd bytes cycles", log_cnt, 2);
    chk_cyc("R9 odd bytes first", 0, 2'd1, 1'b0);
    chk_cyc("R9 odd bytes second", 1, 2'd3, 1'b0);
    run_req(1'b0, 1'b1, 4'b1010, 32'd0, 1'b0, b, m);
    chk("R9 even bytes cycles", log_cnt, 2);
    chk_cyc("R9 even bytes first", 0, 2'd0, 1'b1);
    chk_cyc("R9 even bytes second", 1, 2'd2, 1'b1);
    run_req(1'b0, 1'b1, 4'b0001, 32'd0, 1'b0, b, m);
    chk("R9 three bytes cycles", log_cnt, 2);
    chk_cyc("R9 three bytes first", 0, 2'd1, 1'b0);
    chk_cyc("R9 three bytes pair", 1, 2'd2, 1'b0);
  endtask

  task automatic t_writes;
    int b; logic m;
    mem_w16_n = 1'b1;
    run_req(1'b1, 1'b1, 4'b0000, 32'hD4C3B2A1, 1'b0, b, m);
    chk("R10 8-bit write cycles", log_cnt, 4);
    chk("R10 write flag", {31'd0, log_w[0]}, 32'd1);
    chk("R10 byte 0 low lane", {24'd0, log_d[0][7:0]}, 32'hA1);
    chk("R10 byte 1 both lanes", {16'd0, log_d[1]}, 32'hB2B2);
    chk("R10 byte 2 low lane", {24'd0, log_d[2][7:0]}, 32'hC3);
    chk("R10 byte 3 both lanes", {16'd0, log_d[3]}, 32'hD4D4);
    mem_w16_n = 1'b0;
    run_req(1'b1, 1'b1, 4'b0000, 32'hD4C3B2A1, 1'b0, b, m);
    chk("R10 16-bit write cycles", log_cnt, 2);
    chk("R10 low word lanes", {16'd0, log_d[0]}, 32'hB2A1);
    chk("R10 high word lanes", {16'd0, log_d[1]}, 32'hD4C3);
  endtask

  task automatic t_waits;
    int b; logic m;
    set_mem(32'h87654321);
    mem_w16_n = 1'b0;
    slave_waits = 3;
    stab_err = 0;
    run_req(1'b0, 1'b1, 4'b0000, 32'd0, 1'b0, b, m);
    chk("R11 cycles with waits", log_cnt, 2);
    chk("R11 held during waits", stab_err, 0);
    chk("R1 busy includes waits", b, 8);
    chk("R11 data after waits", cpu_rdata, 32'h87654321);
    slave_waits = 0;
  endtask

  task automatic t_empty;
    int b; logic [31:0] r0; logic m;
    r0 = cpu_rdata;
    run_req(1'b0, 1'b1, 4'b1111, 32'd0, 1'b0, b, m);
    chk("R12 no bus cycle", log_cnt, 0);
    chk("R12 never busy", b, 0);
    chk("R12 rdata unchanged", cpu_rdata, r0);
  endtask

  task automatic t_busy_request;
    int b; logic m;
    mem_w16_n = 1'b1;
    slave_waits = 2;
    run_req(1'b0, 1'b1, 4'b1110, 32'd0, 1'b1, b, m);
    chk("R13 extra request ignored", log_cnt, 1);
    repeat (3) @(negedge clk);
    chk("R13 no later cycle", {31'd0, bus_cyc}, 32'd0);
    chk("R13 no cycle logged after", log_cnt, 1);
    slave_waits = 0;
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_mem = 1'b1;
    req_be_n = 4'hF; req_wdata = '0;
    bus_ready = 1'b0; bus_rdata = '0;
    mem_w16_n = 1'b1; io_w16_n = 1'b1;
    slave_waits = 0; wait_cnt = 0; stab_err = 0; log_cnt = 0;
    waiting = 1'b0; w_a = '0; w_h = 1'b0; w_d = '0;
    set_mem(32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_even_byte();
    t_odd_byte();
    t_word();
    t_dword8();
    t_dword16();
    t_keep_bytes();
    t_width_select();
    t_sparse();
    t_writes();
    t_waits();
    t_empty();
    t_busy_request();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule